// File: doc/BRIEF.md
# Two-Controller SPI Bus Share Arbiter

This block lets two independent SPI controllers, called side A (index 0) and side B (index 1), take turns on one serial memory attached to a single SPI bus. Each side raises a request and waits for its grant. A shared busy output, visible to both sides, reports whether the memory is in use. A side starts a transfer only once it holds the grant. Busy is high exactly while some side owns the bus.

Every side has its own active-low chip-select, serial clock and data-out. Each set passes through a gating stage. A side's pins reach the shared bus only while that side holds the grant and has its own chip-select asserted, so its chip-select works as the enable for its drivers. The block models tri-state drivers as one drive-enable output per side plus a combined bus value, which keeps it synthesizable. The memory's data-out goes back only to the side that is driving. All ports are plain control and status pins. The block has no streaming data interface, so it needs no valid/ready handshake and applies no back-pressure.

Top module: `spi_share_top`

## Requirements
- R1: While reset is low and in the first cycle after it, `grant_o` is 00, `busy_o` is 0, `drv_en_o` is 00, `bus_cs_n_o` is 1, `bus_sck_o` is the idle clock level and `bus_mosi_o` is 0.
- R2: When the bus is free and exactly one side requests, that side's `grant_o` bit and `busy_o` go high at the next rising clock edge.
- R3: When both sides request on a free bus in the same cycle, the grant alternates between them. The first such tie after reset goes to side A (bit 0). Each later tie goes to the side that did not receive the most recent grant.
- R4: A granted side keeps its grant while its chip-select stays low. A request from the other side does not take the bus away.
- R5: Once the owner has driven its chip-select low, the first cycle in which its chip-select is high again releases the bus. `grant_o` and `busy_o` drop at the next edge. `busy_o` stays low for at least one sampled cycle before any new grant, and the grant never moves directly from one side to the other.
- R6: If a granted side drops its request without ever asserting its chip-select, the grant and busy clear at the next edge.
- R7: `drv_en_o[i]` is high exactly when side i holds the grant and `cs_n_i[i]` is low.
- R8: While a side drives, `bus_cs_n_o`, `bus_sck_o` and `bus_mosi_o` follow that side's pins in the same cycle. With no side driving they sit at 1, the idle clock level (parameter `SCK_IDLE`, default 0) and 0.
- R9: Chip-select, clock and data-out activity from a side that does not hold the grant has no effect on the bus outputs or on its own drive-enable.
- R10: `miso_o[i]` follows `miso_i` only while `drv_en_o[i]` is high and is 0 otherwise.
- R11: At most one `grant_o` bit is high at any time, and any grant implies `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 2 | Bus request per side (bit 0 = A, bit 1 = B) |
| cs_n_i | input | 2 | Active-low chip-select from each side |
| sck_i | input | 2 | Serial clock from each side |
| mosi_i | input | 2 | Serial data-out from each side |
| miso_i | input | 1 | Serial data from the memory |
| grant_o | output | 2 | Grant per side |
| busy_o | output | 1 | Shared memory-in-use line |
| drv_en_o | output | 2 | Per-side enable for the bus drivers |
| bus_cs_n_o | output | 1 | Chip-select to the memory |
| bus_sck_o | output | 1 | Serial clock to the memory |
| bus_mosi_o | output | 1 | Serial data to the memory |
| miso_o | output | 2 | Memory data returned per side |

## Verification
Arbitration is tried with five request patterns. A lone request from each side shows that the basic grant path works for both indices. Two simultaneous ties, one just after reset and one after a completed transfer, separate a true alternating pointer from a fixed priority. A competing request made during a live transfer separates holding the grant from preempting it. An abandoned grant with no chip-select activity shows that ownership clears without a transfer. Stray chip-select, clock and data toggling from the side without the grant, with the data line returning from the memory, separates correct gating from leakage onto the shared bus.

// File: rtl/spi_share_pkg.sv
package spi_share_pkg;
  localparam int SIDES = 2;
  typedef logic side_t;
endpackage

// File: rtl/spi_share_rr.sv
module spi_share_rr
  import spi_share_pkg::*;
(
  input  logic [SIDES-1:0] req,
  input  side_t            last_id,
  output side_t            win
);
  always_comb begin
    if (req == 2'b11) win = ~last_id;
    else if (req[1])  win = 1'b1;
    else              win = 1'b0;
  end
endmodule

// File: rtl/spi_share_owner.sv
module spi_share_owner
  import spi_share_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIDES-1:0] req,
  input  logic [SIDES-1:0] cs_n,
  output logic [SIDES-1:0] grant,
  output logic             busy
);
  logic  own_vld;
  logic  started;
  logic  rel;
  side_t own_id;
  side_t last_id;
  side_t win;

  spi_share_rr u_rr (
    .req     (req),
    .last_id (last_id),
    .win     (win)
  );

  always_comb begin
    rel = 1'b0;
    if (own_vld) begin
      if (started) rel = cs_n[own_id];
      else         rel = !req[own_id] && cs_n[own_id];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      started <= 1'b0;
      own_id  <= 1'b0;
      last_id <= 1'b1;
    end else if (own_vld) begin
      if (rel) begin
        own_vld <= 1'b0;
        started <= 1'b0;
      end else if (!cs_n[own_id]) begin
        started <= 1'b1;
      end
    end else if (|req) begin
      own_vld <= 1'b1;
      own_id  <= win;
      last_id <= win;
      started <= 1'b0;
    end
  end

  for (genvar g = 0; g < SIDES; g++) begin : g_grant
    assign grant[g] = own_vld && (own_id == side_t'(g));
  end

  assign busy = own_vld;
endmodule

// File: rtl/spi_share_gate.sv
module spi_share_gate #(
  parameter logic SCK_IDLE = 1'b0
) (
  input  logic grant,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic drv_en,
  output logic g_cs_n,
  output logic g_sck,
  output logic g_mosi
);
  assign drv_en = grant & ~cs_n;
  assign g_cs_n = drv_en ? cs_n : 1'b1;
  assign g_sck  = drv_en ? sck  : SCK_IDLE;
  assign g_mosi = drv_en & mosi;
endmodule

// File: rtl/spi_share_top.sv
module spi_share_top
  import spi_share_pkg::*;
#(
  parameter logic SCK_IDLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIDES-1:0] req_i,
  input  logic [SIDES-1:0] cs_n_i,
  input  logic [SIDES-1:0] sck_i,
  input  logic [SIDES-1:0] mosi_i,
  input  logic             miso_i,
  output logic [SIDES-1:0] grant_o,
  output logic             busy_o,
  output logic [SIDES-1:0] drv_en_o,
  output logic             bus_cs_n_o,
  output logic             bus_sck_o,
  output logic             bus_mosi_o,
  output logic [SIDES-1:0] miso_o
);
  logic [SIDES-1:0] g_cs_n;
  logic [SIDES-1:0] g_sck;
  logic [SIDES-1:0] g_mosi;

  spi_share_owner u_owner (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_i),
    .cs_n  (cs_n_i),
    .grant (grant_o),
    .busy  (busy_o)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    spi_share_gate #(.SCK_IDLE(SCK_IDLE)) u_gate (
      .grant  (grant_o[s]),
      .cs_n   (cs_n_i[s]),
      .sck    (sck_i[s]),
      .mosi   (mosi_i[s]),
      .drv_en (drv_en_o[s]),
      .g_cs_n (g_cs_n[s]),
      .g_sck  (g_sck[s]),
      .g_mosi (g_mosi[s])
    );
    assign miso_o[s] = drv_en_o[s] & miso_i;
  end

  assign bus_cs_n_o = &g_cs_n;
  assign bus_mosi_o = |g_mosi;

  if (SCK_IDLE) begin : g_sck_hi
    assign bus_sck_o = &g_sck;
  end else begin : g_sck_lo
    assign bus_sck_o = |g_sck;
  end
endmodule

// File: rtl/spi_share_chk.sv
module spi_share_chk
  import spi_share_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SIDES-1:0] req_i,
  input logic [SIDES-1:0] cs_n_i,
  input logic [SIDES-1:0] grant_o,
  input logic             busy_o,
  input logic [SIDES-1:0] drv_en_o,
  input logic             bus_cs_n_o,
  input logic             miso_i,
  input logic [SIDES-1:0] miso_o
);
  p_onehot_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_grant_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != 0) |-> busy_o);
  p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o[0] && !cs_n_i[0]) |=> grant_o[0]);
  p_hold_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o[1] && !cs_n_i[1]) |=> grant_o[1]);
  p_no_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != 0) |=> (grant_o == 0 || grant_o == $past(grant_o)));
  p_drv_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en_o & ~grant_o) == 0);
  p_idle_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en_o == 0) |-> bus_cs_n_o);
  p_miso_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_o & ~drv_en_o) == 0);
endmodule

bind spi_share_top spi_share_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .cs_n_i     (cs_n_i),
  .grant_o    (grant_o),
  .busy_o     (busy_o),
  .drv_en_o   (drv_en_o),
  .bus_cs_n_o (bus_cs_n_o),
  .miso_i     (miso_i),
  .miso_o     (miso_o)
);

// File: tb/spi_share_top_test.sv
module spi_share_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req_i = '0;
  logic [1:0] cs_n_i = 2'b11;
  logic [1:0] sck_i = '0;
  logic [1:0] mosi_i = '0;
  logic       miso_i = 1'b0;
  logic [1:0] grant_o;
  logic       busy_o;
  logic [1:0] drv_en_o;
  logic       bus_cs_n_o;
  logic       bus_sck_o;
  logic       bus_mosi_o;
  logic [1:0] miso_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  spi_share_top uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cs_n_i(cs_n_i),
    .sck_i(sck_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .grant_o(grant_o), .busy_o(busy_o), .drv_en_o(drv_en_o),
    .bus_cs_n_o(bus_cs_n_o), .bus_sck_o(bus_sck_o),
    .bus_mosi_o(bus_mosi_o), .miso_o(miso_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_idle(input string tag);
    chk(tag, {5'd0, bus_cs_n_o, bus_sck_o, bus_mosi_o}, 8'h04);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_i = '0; cs_n_i = 2'b11; sck_i = '0; mosi_i = '0; miso_i = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  // granted side runs a short transfer and releases
  task automatic txn(input int s);
    cs_n_i[s] = 1'b0;
    #1;
    chk("R7 drv_en during transfer", {6'd0, drv_en_o}, 8'(1 << s));
    chk("R8 bus cs follows owner", {7'd0, bus_cs_n_o}, 8'd0);
    sck_i[s] = 1'b1; mosi_i[s] = 1'b1; miso_i = 1'b1;
    #1;
    chk("R8 bus sck/mosi follow owner", {6'd0, bus_sck_o, bus_mosi_o}, 8'h03);
    chk("R10 miso to owner only", {6'd0, miso_o}, 8'(1 << s));
    step();
    sck_i[s] = 1'b0; mosi_i[s] = 1'b0; miso_i = 1'b0;
    cs_n_i[s] = 1'b1; req_i[s] = 1'b0;
    step();
    chk("R5 grant drops after release", {6'd0, grant_o}, 8'd0);
    chk("R5 busy drops after release", {7'd0, busy_o}, 8'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step();
    chk("R1 grant in reset", {6'd0, grant_o}, 8'd0);
    chk("R1 busy in reset", {7'd0, busy_o}, 8'd0);
    rst_n = 1'b1;
    step();
    chk("R1 drv_en after reset", {6'd0, drv_en_o}, 8'd0);
    bus_idle("R1 bus idle after reset");
  endtask

  task automatic t_single(input int s);
    do_reset();
    req_i[s] = 1'b1;
    step();
    chk("R2 lone request granted", {6'd0, grant_o}, 8'(1 << s));
    chk("R2 busy with lone grant", {7'd0, busy_o}, 8'd1);
    txn(s);
  endtask

  task automatic t_tie();
    do_reset();
    req_i = 2'b11;
    step();
    chk("R3 first tie to side A", {6'd0, grant_o}, 8'd1);
    cs_n_i[0] = 1'b0;
    step();
    cs_n_i[0] = 1'b1; req_i[0] = 1'b0;
    step();
    chk("R5 busy gap before next owner", {7'd0, busy_o}, 8'd0);
    step();
    chk("R5 waiting side granted after gap", {6'd0, grant_o}, 8'd2);
    txn(1);
    req_i = 2'b11;
    step();
    chk("R3 second tie alternates to A", {6'd0, grant_o}, 8'd1);
    txn(0);
    step();
    chk("R2 remaining B request granted", {6'd0, grant_o}, 8'd2);
    req_i[1] = 1'b0;
    step();
    req_i = 2'b11;
    step();
    chk("R3 tie after B grant goes to A", {6'd0, grant_o}, 8'd1);
    req_i = 2'b00;
    step(); step();
  endtask

  task automatic t_hold_and_stray();
    do_reset();
    req_i[0] = 1'b1;
    step();
    cs_n_i[0] = 1'b0;
    step();
    req_i[1] = 1'b1; cs_n_i[1] = 1'b0; sck_i[1] = 1'b1; mosi_i[1] = 1'b1; miso_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R4 grant held against competitor", {6'd0, grant_o}, 8'd1);
    end
    chk("R9 stray side not enabled", {6'd0, drv_en_o}, 8'd1);
    chk("R9 stray sck/mosi absent from bus", {6'd0, bus_sck_o, bus_mosi_o}, 8'd0);
    chk("R10 stray side gets no miso", {6'd0, miso_o}, 8'd1);
    cs_n_i = 2'b11; sck_i = '0; mosi_i = '0; miso_i = 1'b0; req_i = '0;
    step();
    chk("R5 release with idle competitor", {6'd0, grant_o}, 8'd0);
    req_i = 2'b00;
    cs_n_i[1] = 1'b0; sck_i[1] = 1'b1; mosi_i[1] = 1'b1;
    step();
    chk("R9 no grant: drv_en low", {6'd0, drv_en_o}, 8'd0);
    bus_idle("R8 bus idle with stray pins");
    cs_n_i = 2'b11; sck_i = '0; mosi_i = '0;
  endtask

  task automatic t_abandon();
    do_reset();
    req_i[1] = 1'b1;
    step();
    chk("R2 B granted", {6'd0, grant_o}, 8'd2);
    req_i[1] = 1'b0;
    step();
    chk("R6 abandoned grant cleared", {6'd0, grant_o}, 8'd0);
    chk("R6 busy cleared on abandon", {7'd0, busy_o}, 8'd0);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single(0);
    t_single(1);
    t_tie();
    t_hold_and_stray();
    t_abandon();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule